// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the storage cell that sits behind one output of a programmable-logic array. Static configuration inputs turn the same single bit of state into a D, T, JK or SR flip-flop or into a transparent latch. They also pick where its data comes from, which clock drives it and whether a clock-enable term gates that clock. A separate set of inputs decides which asynchronous clear and preset terms can force the state.

The product terms, the sum-term result and the pin value arrive already computed from the surrounding array. The cell delivers two results: the pin-facing output and a buried feedback line for the interconnect. Each can show either the stored bit or the combinational sum-term result, chosen separately. An active-low block reset clears the state. Its release is assumed to be timed by the reset network outside the cell.

Top module: `macro_reg_cell`

## Requirements
- R1: `data_src` picks the selected data bit: 0 = `xor_in`, 1 = `pt_data`, 2 or 3 = `pin_in`. In D mode (`mode`=0) the state takes the selected data at the active clock edge.
- R2: In flip-flop modes the state changes only on a rising edge of the selected clock. A falling edge, or a change of data while the clock is high, leaves the state unchanged.
- R3: In T mode (`mode`=1), a selected data bit of 1 inverts the state at the edge and a 0 keeps it.
- R4: In JK mode (`mode`=2), J is the selected data bit and K is `aux_term`. The pair {J,K} acts as follows: 00 keeps the state, 01 clears it, 10 sets it and 11 inverts it.
- R5: In SR mode (`mode`=3), S is the selected data bit and R is `aux_term`. S alone sets the state, R alone clears it, and both high or both low keep it.
- R6: In latch mode (`mode`=4), the state follows the selected data while the selected clock is high and holds it while the clock is low.
- R7: `clk_src` values 0 to 2 select `gclk[0]` to `gclk[2]`, and 3 selects `pt_clk`. Edges on the clocks that are not selected have no effect.
- R8: With a global clock selected and `ce_en`=1, an edge while `ce_term`=0 is ignored and an edge while `ce_term`=1 is taken. With `ce_en`=0, every edge is taken whatever `ce_term` is.
- R9: When `pt_clk` is selected, `ce_term` is ignored even if `ce_en`=1.
- R10: `ar_sel` chooses the asynchronous clear: 0 = none, 1 = `gclear`, 2 = `pt_ar`, 3 = either one. An active clear forces the state to 0 at once, without a clock.
- R11: With `ap_en`=1, `pt_ap` high forces the state to 1 at once. With `ap_en`=0, `pt_ap` has no effect. When a clear and a preset are active together, the state is 0.
- R12: `out_reg`=1 puts the state on `cell_out`, and `out_reg`=0 puts `xor_in` there. `fb_reg` makes the same choice for `fb_out`, independently of `out_reg`.
- R13: `rst_n` low forces the state to 0, and the state stays 0 after `rst_n` is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Block reset, active low, asynchronous |
| mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| data_src | input | 2 | Data source: 0 sum term, 1 data product term, 2/3 pin |
| clk_src | input | CKSEL_W (2) | Clock source: 0..N_GCLK-1 global clock, N_GCLK product-term clock |
| ce_en | input | 1 | Use `ce_term` as clock enable when a global clock drives the cell |
| ar_sel | input | 2 | Asynchronous clear source select |
| ap_en | input | 1 | Enables the preset product term |
| out_reg | input | 1 | 1 = stored bit on `cell_out`, 0 = sum term |
| fb_reg | input | 1 | 1 = stored bit on `fb_out`, 0 = sum term |
| gclk | input | N_GCLK (3) | Global clocks |
| pt_clk | input | 1 | Per-cell product-term clock |
| ce_term | input | 1 | Clock-enable product term |
| gclear | input | 1 | Global clear |
| pt_ar | input | 1 | Clear product term |
| pt_ap | input | 1 | Preset product term |
| xor_in | input | 1 | Sum-term (XOR gate) result |
| pt_data | input | 1 | Dedicated data product term |
| pin_in | input | 1 | Value at the I/O pin |
| aux_term | input | 1 | Second operand: K in JK mode, R in SR mode |
| cell_out | output | 1 | Pin-facing output |
| fb_out | output | 1 | Buried feedback output |

## Verification
The hardest case to reach from the ports is the one where a clear and a preset are both active at the same moment. Proving that the clear wins needs the state first driven to 1 by the preset, and then the clear raised while the preset is still held. The bench does this with the clear taken from the product term, and again with the global clear. It then releases both and checks that the state stays 0. A second case needs care: the same bit value is fed on one data source while the opposite value sits on the others. This shows which source the cell took. The clock-source checks pulse every unselected clock before the selected one, so a stray capture would show up as a 1.

// File: rtl/mrc_pkg.sv
package mrc_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } store_mode_e;

  typedef enum logic [1:0] {
    DSRC_SUM  = 2'd0,
    DSRC_TERM = 2'd1,
    DSRC_PIN  = 2'd2,
    DSRC_PIN2 = 2'd3
  } data_src_e;

  typedef enum logic [1:0] {
    CLR_NONE   = 2'd0,
    CLR_GLOBAL = 2'd1,
    CLR_TERM   = 2'd2,
    CLR_EITHER = 2'd3
  } clr_src_e;

endpackage

// File: rtl/mrc_clk_sel.sv
module mrc_clk_sel #(
  parameter int N_GCLK = 3,
  localparam int CKSEL_W = $clog2(N_GCLK + 1)
) (
  input  logic [N_GCLK-1:0]  gclk,
  input  logic               pt_clk,
  input  logic [CKSEL_W-1:0] clk_src,
  input  logic               ce_en,
  input  logic               ce_term,
  output logic               cell_clk,
  output logic               take_edge
);

  localparam int N_SRC = N_GCLK + 1;

  logic [N_SRC-1:0] src_hit;
  logic [N_SRC-1:0] clk_vec;
  logic             on_global;

  // one compare per global clock, the product-term clock in the top slot
  for (genvar g = 0; g < N_GCLK; g++) begin : g_glob
    assign src_hit[g] = (clk_src == CKSEL_W'(g));
    assign clk_vec[g] = gclk[g];
  end
  assign src_hit[N_GCLK] = (clk_src == CKSEL_W'(N_GCLK));
  assign clk_vec[N_GCLK] = pt_clk;

  assign cell_clk  = |(src_hit & clk_vec);
  assign on_global = |src_hit[N_GCLK-1:0];

  // enable only qualifies global clocks; product-term clock always takes edges
  always_comb begin
    if (ce_en && on_global) take_edge = ce_term;
    else                    take_edge = 1'b1;
  end

endmodule

// File: rtl/mrc_async_sel.sv
module mrc_async_sel
  import mrc_pkg::*;
(
  input  logic       rst_n,
  input  logic [1:0] ar_sel,
  input  logic       gclear,
  input  logic       pt_ar,
  input  logic       ap_en,
  input  logic       pt_ap,
  output logic       force_clr,
  output logic       force_set
);

  clr_src_e sel;
  logic     cfg_clr;

  assign sel = clr_src_e'(ar_sel);

  always_comb begin
    unique case (sel)
      CLR_GLOBAL: cfg_clr = gclear;
      CLR_TERM:   cfg_clr = pt_ar;
      CLR_EITHER: cfg_clr = gclear | pt_ar;
      default:    cfg_clr = 1'b0;
    endcase
  end

  assign force_clr = cfg_clr | ~rst_n;
  assign force_set = ap_en & pt_ap;

endmodule

// File: rtl/mrc_next_state.sv
module mrc_next_state
  import mrc_pkg::*;
(
  input  logic [2:0] mode,
  input  logic [1:0] data_src,
  input  logic       xor_in,
  input  logic       pt_data,
  input  logic       pin_in,
  input  logic       aux_term,
  input  logic       cur,
  output logic       d_sel,
  output logic       nxt
);

  store_mode_e m;
  data_src_e   s;

  assign m = store_mode_e'(mode);
  assign s = data_src_e'(data_src);

  always_comb begin
    unique case (s)
      DSRC_SUM:  d_sel = xor_in;
      DSRC_TERM: d_sel = pt_data;
      default:   d_sel = pin_in;
    endcase
  end

  always_comb begin
    nxt = d_sel;
    unique case (m)
      MODE_T:  nxt = cur ^ d_sel;
      MODE_JK: begin
        unique case ({d_sel, aux_term})
          2'b01:   nxt = 1'b0;
          2'b10:   nxt = 1'b1;
          2'b11:   nxt = ~cur;
          default: nxt = cur;
        endcase
      end
      MODE_SR: begin
        unique case ({d_sel, aux_term})
          2'b10:   nxt = 1'b1;
          2'b01:   nxt = 1'b0;
          default: nxt = cur;
        endcase
      end
      default: nxt = d_sel;
    endcase
  end

endmodule

// File: rtl/mrc_store.sv
module mrc_store (
  input  logic cell_clk,
  input  logic take_edge,
  input  logic is_latch,
  input  logic nxt,
  input  logic d_lat,
  input  logic force_clr,
  input  logic force_set,
  output logic ff_q,
  output logic q
);

  logic lat_q;

  // edge storage: clear has priority over preset
  always_ff @(posedge cell_clk or posedge force_clr or posedge force_set) begin
    if (force_clr)      ff_q <= 1'b0;
    else if (force_set) ff_q <= 1'b1;
    else if (take_edge) ff_q <= nxt;
  end

  // level storage: open while the selected clock is high and enabled
  always_latch begin
    if (force_clr)                   lat_q <= 1'b0;
    else if (force_set)              lat_q <= 1'b1;
    else if (cell_clk && take_edge)  lat_q <= d_lat;
  end

  assign q = is_latch ? lat_q : ff_q;

endmodule

// File: rtl/macro_reg_cell.sv
module macro_reg_cell
  import mrc_pkg::*;
#(
  parameter int N_GCLK = 3,
  localparam int CKSEL_W = $clog2(N_GCLK + 1)
) (
  input  logic               rst_n,
  input  logic [2:0]         mode,
  input  logic [1:0]         data_src,
  input  logic [CKSEL_W-1:0] clk_src,
  input  logic               ce_en,
  input  logic [1:0]         ar_sel,
  input  logic               ap_en,
  input  logic               out_reg,
  input  logic               fb_reg,
  input  logic [N_GCLK-1:0]  gclk,
  input  logic               pt_clk,
  input  logic               ce_term,
  input  logic               gclear,
  input  logic               pt_ar,
  input  logic               pt_ap,
  input  logic               xor_in,
  input  logic               pt_data,
  input  logic               pin_in,
  input  logic               aux_term,
  output logic               cell_out,
  output logic               fb_out
);

  logic cell_clk;
  logic take_edge;
  logic force_clr;
  logic force_set;
  logic d_sel;
  logic nxt;
  logic ff_q;
  logic q_state;
  logic is_latch;

  assign is_latch = (store_mode_e'(mode) == MODE_LATCH);

  mrc_clk_sel #(.N_GCLK(N_GCLK)) u_clk_sel (
    .gclk      (gclk),
    .pt_clk    (pt_clk),
    .clk_src   (clk_src),
    .ce_en     (ce_en),
    .ce_term   (ce_term),
    .cell_clk  (cell_clk),
    .take_edge (take_edge)
  );

  mrc_async_sel u_async_sel (
    .rst_n     (rst_n),
    .ar_sel    (ar_sel),
    .gclear    (gclear),
    .pt_ar     (pt_ar),
    .ap_en     (ap_en),
    .pt_ap     (pt_ap),
    .force_clr (force_clr),
    .force_set (force_set)
  );

  mrc_next_state u_next_state (
    .mode     (mode),
    .data_src (data_src),
    .xor_in   (xor_in),
    .pt_data  (pt_data),
    .pin_in   (pin_in),
    .aux_term (aux_term),
    .cur      (ff_q),
    .d_sel    (d_sel),
    .nxt      (nxt)
  );

  mrc_store u_store (
    .cell_clk  (cell_clk),
    .take_edge (take_edge),
    .is_latch  (is_latch),
    .nxt       (nxt),
    .d_lat     (d_sel),
    .force_clr (force_clr),
    .force_set (force_set),
    .ff_q      (ff_q),
    .q         (q_state)
  );

  assign cell_out = out_reg ? q_state : xor_in;
  assign fb_out   = fb_reg  ? q_state : xor_in;

endmodule

// File: rtl/macro_reg_cell_chk.sv
module macro_reg_cell_chk #(
  parameter int N_GCLK = 3,
  localparam int CKSEL_W = $clog2(N_GCLK + 1)
) (
  input logic               rst_n,
  input logic [2:0]         mode,
  input logic [1:0]         data_src,
  input logic [CKSEL_W-1:0] clk_src,
  input logic               ce_en,
  input logic [1:0]         ar_sel,
  input logic               ap_en,
  input logic               out_reg,
  input logic               fb_reg,
  input logic [N_GCLK-1:0]  gclk,
  input logic               ce_term,
  input logic               gclear,
  input logic               pt_ar,
  input logic               pt_ap,
  input logic               xor_in,
  input logic               cell_out,
  input logic               fb_out,
  input logic               q_state
);

  logic clr_req;
  logic set_req;
  logic armed;
  logic want;

  assign clr_req = (ar_sel[0] & gclear) | (ar_sel[1] & pt_ar);
  assign set_req = ap_en & pt_ap;

  // record what a D cell on gclk[0] fed by the sum term must hold after this rise
  always_ff @(posedge gclk[0] or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      want  <= 1'b0;
    end else begin
      armed <= (mode == 3'd0) && (clk_src == CKSEL_W'(0)) && (data_src == 2'd0)
               && !clr_req && !set_req;
      want  <= (ce_en && !ce_term) ? q_state : xor_in;
    end
  end

  // R10
  clear_forces_low_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    clr_req |-> !q_state);

  // R11
  preset_forces_high_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    (set_req && !clr_req) |-> q_state);

  // R12
  out_fb_agree_chk: assert property (@(posedge gclk[0]) disable iff (!rst_n)
    (out_reg == fb_reg) |-> (cell_out == fb_out));

  // R8
  d_edge_capture_chk: assert property (@(negedge gclk[0]) disable iff (!rst_n)
    (armed && !clr_req && !set_req) |-> (q_state == want));

endmodule

bind macro_reg_cell macro_reg_cell_chk #(.N_GCLK(N_GCLK)) u_chk (
  .rst_n    (rst_n),
  .mode     (mode),
  .data_src (data_src),
  .clk_src  (clk_src),
  .ce_en    (ce_en),
  .ar_sel   (ar_sel),
  .ap_en    (ap_en),
  .out_reg  (out_reg),
  .fb_reg   (fb_reg),
  .gclk     (gclk),
  .ce_term  (ce_term),
  .gclear   (gclear),
  .pt_ar    (pt_ar),
  .pt_ap    (pt_ap),
  .xor_in   (xor_in),
  .cell_out (cell_out),
  .fb_out   (fb_out),
  .q_state  (q_state)
);

// File: tb/test_macro_reg_cell.sv
module test_macro_reg_cell;

  logic       clk;
  logic       rst_n;
  logic [2:0] mode;
  logic [1:0] data_src, clk_src, ar_sel;
  logic       ce_en, ap_en, out_reg, fb_reg;
  logic [2:0] gclk;
  logic       pt_clk, ce_term, gclear, pt_ar, pt_ap;
  logic       xor_in, pt_data, pin_in, aux_term;
  logic       cell_out, fb_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  macro_reg_cell #(.N_GCLK(3)) i_macro_reg_cell (
    .rst_n(rst_n), .mode(mode), .data_src(data_src), .clk_src(clk_src),
    .ce_en(ce_en), .ar_sel(ar_sel), .ap_en(ap_en), .out_reg(out_reg),
    .fb_reg(fb_reg), .gclk(gclk), .pt_clk(pt_clk), .ce_term(ce_term),
    .gclear(gclear), .pt_ar(pt_ar), .pt_ap(pt_ap), .xor_in(xor_in),
    .pt_data(pt_data), .pin_in(pin_in), .aux_term(aux_term),
    .cell_out(cell_out), .fb_out(fb_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic set_clk(input int s, input logic v);
    if (s < 3) gclk[s] = v;
    else       pt_clk  = v;
  endtask

  task automatic pulse(input int s);
    set_clk(s, 1'b1); #2;
    set_clk(s, 1'b0); #2;
  endtask

  task automatic wipe();
    ar_sel = 2'd1; gclear = 1'b1; #1;
    gclear = 1'b0; ar_sel = 2'd0; #1;
  endtask

  task automatic preload1();
    ap_en = 1'b1; pt_ap = 1'b1; #1;
    pt_ap = 1'b0; ap_en = 1'b0; #1;
  endtask

  task automatic t_reset();
    preload1();
    chk("R13 preset before reset", cell_out, 1'b1);
    rst_n = 1'b0; #1;
    chk("R13 reset forces 0", cell_out, 1'b0);
    rst_n = 1'b1; #1;
    chk("R13 stays 0 after release", cell_out, 1'b0);
  endtask

  task automatic t_dsrc();
    mode = 3'd0; clk_src = 2'd0; ce_en = 1'b0;
    for (int s = 0; s < 4; s++) begin
      data_src = 2'(s);
      wipe();
      xor_in = (s == 0); pt_data = (s == 1); pin_in = (s >= 2);
      pulse(0);
      chk($sformatf("R1 src %0d takes 1", s), cell_out, 1'b1);
      xor_in = (s != 0); pt_data = (s != 1); pin_in = (s < 2);
      pulse(0);
      chk($sformatf("R1 src %0d takes 0", s), cell_out, 1'b0);
    end
    xor_in = 1'b0; pt_data = 1'b0; pin_in = 1'b0; data_src = 2'd0;
  endtask

  task automatic t_edge();
    mode = 3'd0; clk_src = 2'd0; data_src = 2'd0;
    wipe();
    xor_in = 1'b1;
    gclk[0] = 1'b1; #1;
    chk("R2 rising edge captures", cell_out, 1'b1);
    xor_in = 1'b0; #1;
    chk("R2 no change while high", cell_out, 1'b1);
    gclk[0] = 1'b0; #1;
    chk("R2 falling edge ignored", cell_out, 1'b1);
    pulse(0);
    chk("R2 next rising edge captures 0", cell_out, 1'b0);
  endtask

  task automatic t_toggle();
    mode = 3'd1; clk_src = 2'd0; data_src = 2'd0;
    wipe();
    xor_in = 1'b1;
    pulse(0); chk("R3 T=1 toggles to 1", cell_out, 1'b1);
    pulse(0); chk("R3 T=1 toggles to 0", cell_out, 1'b0);
    xor_in = 1'b0;
    pulse(0); chk("R3 T=0 holds 0", cell_out, 1'b0);
    preload1();
    pulse(0); chk("R3 T=0 holds 1", cell_out, 1'b1);
  endtask

  task automatic t_jk();
    mode = 3'd2; clk_src = 2'd1; data_src = 2'd0;
    wipe();
    xor_in = 1'b1; aux_term = 1'b0; pulse(1); chk("R4 JK 10 sets", cell_out, 1'b1);
    xor_in = 1'b0; aux_term = 1'b0; pulse(1); chk("R4 JK 00 holds", cell_out, 1'b1);
    xor_in = 1'b0; aux_term = 1'b1; pulse(1); chk("R4 JK 01 clears", cell_out, 1'b0);
    xor_in = 1'b1; aux_term = 1'b1; pulse(1); chk("R4 JK 11 toggles up", cell_out, 1'b1);
    pulse(1); chk("R4 JK 11 toggles down", cell_out, 1'b0);
    xor_in = 1'b0; aux_term = 1'b0;
  endtask

  task automatic t_sr();
    mode = 3'd3; clk_src = 2'd1; data_src = 2'd0;
    wipe();
    xor_in = 1'b1; aux_term = 1'b0; pulse(1); chk("R5 S sets", cell_out, 1'b1);
    xor_in = 1'b0; aux_term = 1'b0; pulse(1); chk("R5 none holds", cell_out, 1'b1);
    xor_in = 1'b1; aux_term = 1'b1; pulse(1); chk("R5 both hold 1", cell_out, 1'b1);
    xor_in = 1'b0; aux_term = 1'b1; pulse(1); chk("R5 R clears", cell_out, 1'b0);
    xor_in = 1'b1; aux_term = 1'b1; pulse(1); chk("R5 both hold 0", cell_out, 1'b0);
    xor_in = 1'b0; aux_term = 1'b0;
  endtask

  task automatic t_latch();
    mode = 3'd4; clk_src = 2'd1; data_src = 2'd0; ce_en = 1'b0;
    wipe();
    gclk[1] = 1'b1;
    xor_in = 1'b1; #1; chk("R6 transparent follows 1", cell_out, 1'b1);
    xor_in = 1'b0; #1; chk("R6 transparent follows 0", cell_out, 1'b0);
    xor_in = 1'b1; #1;
    gclk[1] = 1'b0; #1;
    xor_in = 1'b0; #1; chk("R6 holds while clock low", cell_out, 1'b1);
    wipe();
  endtask

  task automatic t_clksrc();
    mode = 3'd0; data_src = 2'd0; ce_en = 1'b0;
    for (int s = 0; s < 4; s++) begin
      clk_src = 2'(s);
      wipe();
      xor_in = 1'b1;
      for (int o = 0; o < 4; o++) if (o != s) pulse(o);
      chk($sformatf("R7 other clocks ignored for src %0d", s), cell_out, 1'b0);
      pulse(s);
      chk($sformatf("R7 selected clock %0d captures", s), cell_out, 1'b1);
    end
    xor_in = 1'b0;
  endtask

  task automatic t_ce();
    mode = 3'd0; data_src = 2'd0; clk_src = 2'd2;
    wipe();
    ce_en = 1'b1; ce_term = 1'b0; xor_in = 1'b1;
    pulse(2); chk("R8 enable low ignores edge", cell_out, 1'b0);
    ce_term = 1'b1;
    pulse(2); chk("R8 enable high takes edge", cell_out, 1'b1);
    clk_src = 2'd0; ce_term = 1'b0; xor_in = 1'b0;
    pulse(0); chk("R8 enable low holds on gclk0", cell_out, 1'b1);
    ce_en = 1'b0;
    pulse(0); chk("R8 enable unused takes edge", cell_out, 1'b0);
  endtask

  task automatic t_ptce();
    mode = 3'd0; data_src = 2'd0; clk_src = 2'd3;
    wipe();
    ce_en = 1'b1; ce_term = 1'b0; xor_in = 1'b1;
    pulse(3); chk("R9 product clock ignores enable", cell_out, 1'b1);
    ce_en = 1'b0; xor_in = 1'b0; clk_src = 2'd0;
  endtask

  task automatic t_clear();
    for (int s = 0; s < 4; s++) begin
      ar_sel = 2'(s);
      preload1();
      gclear = 1'b1; #1;
      chk($sformatf("R10 sel %0d global clear", s), cell_out, (s == 1 || s == 3) ? 1'b0 : 1'b1);
      gclear = 1'b0; #1;
      preload1();
      pt_ar = 1'b1; #1;
      chk($sformatf("R10 sel %0d term clear", s), cell_out, (s == 2 || s == 3) ? 1'b0 : 1'b1);
      pt_ar = 1'b0; #1;
    end
    ar_sel = 2'd0;
  endtask

  task automatic t_preset();
    wipe();
    ap_en = 1'b0; pt_ap = 1'b1; #1;
    chk("R11 preset disabled has no effect", cell_out, 1'b0);
    ap_en = 1'b1; #1;
    chk("R11 preset forces 1", cell_out, 1'b1);
    ar_sel = 2'd2; pt_ar = 1'b1; #1;
    chk("R11 term clear beats preset", cell_out, 1'b0);
    pt_ar = 1'b0; ar_sel = 2'd1; gclear = 1'b1; #1;
    chk("R11 global clear beats preset", cell_out, 1'b0);
    pt_ap = 1'b0; #1; gclear = 1'b0; ar_sel = 2'd0; ap_en = 1'b0; #1;
    chk("R11 zero kept after release", cell_out, 1'b0);
  endtask

  task automatic t_outsel();
    preload1();
    xor_in = 1'b0;
    out_reg = 1'b1; fb_reg = 1'b0; #1;
    chk("R12 out registered", cell_out, 1'b1);
    chk("R12 fb combinational", fb_out, 1'b0);
    out_reg = 1'b0; fb_reg = 1'b1; #1;
    chk("R12 out combinational", cell_out, 1'b0);
    chk("R12 fb registered", fb_out, 1'b1);
    xor_in = 1'b1; wipe();
    chk("R12 out follows sum term", cell_out, 1'b1);
    chk("R12 fb shows stored 0", fb_out, 1'b0);
    out_reg = 1'b1; fb_reg = 1'b1; xor_in = 1'b0; #1;
  endtask

  initial begin
    rst_n = 1'b0; mode = 3'd0; data_src = 2'd0; clk_src = 2'd0; ar_sel = 2'd0;
    ce_en = 1'b0; ap_en = 1'b0; out_reg = 1'b1; fb_reg = 1'b1; gclk = 3'b000;
    pt_clk = 1'b0; ce_term = 1'b0; gclear = 1'b0; pt_ar = 1'b0; pt_ap = 1'b0;
    xor_in = 1'b0; pt_data = 1'b0; pin_in = 1'b0; aux_term = 1'b0;
    #5;
    chk("R13 reset state", cell_out, 1'b0);
    rst_n = 1'b1; #2;
    t_reset();
    t_dsrc();
    t_edge();
    t_toggle();
    t_jk();
    t_sr();
    t_latch();
    t_clksrc();
    t_ce();
    t_ptce();
    t_clear();
    t_preset();
    t_outsel();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule